// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block connects a simple synchronous request port to an external asynchronous static RAM that holds 65536 words of 16 bits. A requester raises `req_valid` with a write flag, a word address, write data and two byte enables. It holds these inputs steady until `req_ready` rises for one cycle. For a read, the returned word is on `rsp_rdata` in that same cycle.

On the memory side the controller drives the word address, a pair of chip selects with opposite polarity, output enable, write enable, and one active-low strobe for each byte lane. It also drives a split data bus: an outgoing word, a driver enable, and an incoming word. Every access holds the pins steady for a fixed number of clock cycles, set by a parameter, so that the memory's access time is met at the chosen clock rate.

Between accesses the memory is parked in standby. Both selects are inactive, both byte strobes are high and the data driver is off. A write that follows a read waits one extra parked cycle so that the two drivers never overlap on the bus.

Top module: `sram_byte_ctl`

## Requirements
- R1: After reset and in every idle cycle, the memory pins are parked: `mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_ub_n`=1, `mem_lb_n`=1, `mem_dq_oe`=0, and `req_ready`=0.
- R2: A request with a nonzero byte enable holds the memory selected (`mem_cs1_n`=0 and `mem_cs2`=1) for exactly WAIT_CYCLES consecutive cycles. `req_ready` is high only in the single cycle that follows the last selected cycle.
- R3: During every selected cycle of a write, `mem_we_n`=0, `mem_oe_n`=1, `mem_dq_oe`=1, `mem_addr` equals the request address and `mem_dq_out` equals the request data.
- R4: During every selected cycle of a read, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0. The word on `mem_dq_in` in the last selected cycle is returned on `rsp_rdata` while `req_ready` is high.
- R5: During selected cycles, `mem_lb_n` is low exactly when `req_be[0]`=1 (bits 7:0) and `mem_ub_n` is low exactly when `req_be[1]`=1 (bits 15:8). Read data in a disabled lane returns as zero.
- R6: In the cycle after the last selected cycle of a write, `mem_we_n` is high while `mem_addr` and `mem_dq_out` are unchanged and `mem_dq_oe` is still 1.
- R7: A write with nonzero byte enables that follows a completed read starts its selected cycles one cycle later. In that extra cycle the pins stay parked with `mem_dq_oe`=0. A write that follows a write, and a read that follows a read, get no extra cycle.
- R8: A request whose byte enables are both zero raises `req_ready` in the cycle after it is accepted, never selects the memory, and leaves memory contents unchanged. A read of this kind returns zero.
- R9: The controller never drives the data bus while the memory's output enable is active. It never selects the memory with both byte strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `req_ready` |
| mem_addr | output | 16 | Memory word address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_ub_n | output | 1 | Active-low upper byte strobe |
| mem_lb_n | output | 1 | Active-low lower byte strobe |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data returned from the memory |

## Verification
The bench builds the controller with WAIT_CYCLES set to 4 rather than the default 3. This makes the wait counter pass through several values, so an off-by-one in the access window shows up as a wrong count of selected cycles. It also lets the bench check that the pins stay stable across a long window. A behavioural memory model with its own byte lanes, driven from the pins, brings the following cases within reach:
- partial-lane reads and writes;
- the extra parked cycle for a write after a read, including when a zero-enable request sits in between;
- an access at the top address.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    // One-hot so that each pin decode is a single-term gate off a flop.
    typedef enum logic [3:0] {
        ST_IDLE = 4'b0001,
        ST_TURN = 4'b0010,
        ST_ACC  = 4'b0100,
        ST_DONE = 4'b1000
    } seq_state_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
    } access_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              cs1_n;
        logic              cs2;
        logic              oe_n;
        logic              we_n;
        logic [DATA_W-1:0] dq_out;
        logic              dq_oe;
    } pins_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int WAIT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST_VAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == LAST_VAL);

    // The counter never passes the end of the window (R2).
    assert_window_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= LAST_VAL));

    // Count restarts at zero whenever a window opens (R2).
    assert_window_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              acc_last,
    input  logic [DATA_W-1:0] dq_in,
    output seq_state_t        state,
    output access_t           cur,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    logic after_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur        <= '0;
            rdata      <= '0;
            after_read <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur.wr   <= req_write;
                        cur.addr <= req_addr;
                        cur.data <= req_wdata;
                        cur.be   <= req_be;
                        if (req_be == '0) begin
                            state <= ST_DONE;
                            rdata <= '0;
                        end else if (req_write && after_read) begin
                            state <= ST_TURN;
                        end else begin
                            state <= ST_ACC;
                        end
                    end
                end
                ST_TURN: state <= ST_ACC;
                ST_ACC: begin
                    if (acc_last) begin
                        state      <= ST_DONE;
                        after_read <= !cur.wr;
                        if (!cur.wr) begin
                            rdata <= dq_in & lane_mask(cur.be);
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready = (state == ST_DONE);

    // A parked turnaround cycle is always followed by an access (R7).
    assert_turn_then_access_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TURN) |=> (state == ST_ACC));

    // Only writes ever pass through the turnaround cycle (R7).
    assert_turn_only_write_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TURN) |-> cur.wr);

    // State stays one-hot.
    assert_state_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot(state));

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_state_t       state,
    input  access_t          cur,
    output pins_t            pins,
    output logic [LANES-1:0] lane_n
);
    logic in_acc;
    assign in_acc = (state == ST_ACC);

    always_comb begin
        pins.addr   = cur.addr;
        pins.dq_out = cur.data;
        pins.cs1_n  = 1'b1;
        pins.cs2    = 1'b0;
        pins.oe_n   = 1'b1;
        pins.we_n   = 1'b1;
        pins.dq_oe  = 1'b0;
        if (in_acc) begin
            pins.cs1_n = 1'b0;
            pins.cs2   = 1'b1;
            pins.we_n  = !cur.wr;
            pins.oe_n  = cur.wr;
            pins.dq_oe = cur.wr;
        end else if (state == ST_DONE) begin
            // Data held one cycle past the write strobe for hold time.
            pins.dq_oe = cur.wr && (cur.be != '0);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = !(in_acc && cur.be[g]);
    end

    // No overlap of the two bus drivers (R9).
    assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
        !(pins.dq_oe && !pins.oe_n && !pins.cs1_n && pins.cs2));

    // Selected memory always has at least one lane strobe active (R9).
    assert_no_empty_select_R9: assert property (@(posedge clk) disable iff (rst)
        (!pins.cs1_n && pins.cs2) |-> (lane_n != '1));

    // Write strobe comes with outputs off and our driver on (R3).
    assert_write_pins_R3: assert property (@(posedge clk) disable iff (rst)
        !pins.we_n |-> (pins.oe_n && pins.dq_oe && !pins.cs1_n));

    // Output enable only with the driver off and no write strobe (R4).
    assert_read_pins_R4: assert property (@(posedge clk) disable iff (rst)
        !pins.oe_n |-> (!pins.dq_oe && pins.we_n));

endmodule

// File: rtl/sram_byte_ctl.sv
module sram_byte_ctl
    import sram_ctl_pkg::*;
#(
    parameter int WAIT_CYCLES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [1:0]  req_be,
    output logic        req_ready,
    output logic [15:0] rsp_rdata,
    output logic [15:0] mem_addr,
    output logic        mem_cs1_n,
    output logic        mem_cs2,
    output logic        mem_oe_n,
    output logic        mem_we_n,
    output logic        mem_ub_n,
    output logic        mem_lb_n,
    output logic [15:0] mem_dq_out,
    output logic        mem_dq_oe,
    input  logic [15:0] mem_dq_in
);
    seq_state_t       state;
    access_t          cur;
    pins_t            pins;
    logic [LANES-1:0] lane_n;
    logic             acc_last;

    sram_ctl_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_ACC),
        .last (acc_last)
    );

    sram_ctl_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .acc_last  (acc_last),
        .dq_in     (mem_dq_in),
        .state     (state),
        .cur       (cur),
        .rdata     (rsp_rdata),
        .ready     (req_ready)
    );

    sram_ctl_pins u_pins (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .cur    (cur),
        .pins   (pins),
        .lane_n (lane_n)
    );

    assign mem_addr   = pins.addr;
    assign mem_cs1_n  = pins.cs1_n;
    assign mem_cs2    = pins.cs2;
    assign mem_oe_n   = pins.oe_n;
    assign mem_we_n   = pins.we_n;
    assign mem_dq_out = pins.dq_out;
    assign mem_dq_oe  = pins.dq_oe;
    assign mem_lb_n   = lane_n[0];
    assign mem_ub_n   = lane_n[1];

    // Completion pulse lasts a single cycle (R2).
    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    // Releasing the write strobe leaves address and data in place (R6).
    assert_write_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

    // Empty byte enables finish next cycle without a select (R8).
    assert_empty_request_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && req_be == '0) |=> (req_ready && mem_cs1_n && !mem_cs2));

    // Idle cycles keep the memory parked (R1).
    assert_idle_parked_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (mem_cs1_n && !mem_cs2 && mem_ub_n && mem_lb_n && !mem_dq_oe));

endmodule

// File: tb/test_sram_byte_ctl.sv
module test_sram_byte_ctl;

    localparam int WAITN = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    int checks = 0;
    int fails  = 0;
    bit prev_read = 1'b0;
    bit finished = 1'b0;

    logic [15:0] sram [int];
    logic [15:0] shadow [int];

    always #2 clk = ~clk;

    sram_byte_ctl #(.WAIT_CYCLES(WAITN)) i_sram_byte_ctl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
        .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [15:0] peek_sram(input int a);
        return sram.exists(a) ? sram[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] peek_shadow(input int a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    // Behavioural memory: undriven lanes read back a filler pattern.
    wire sel = !mem_cs1_n && mem_cs2;
    always_comb begin
        mem_dq_in = 16'hC3C3;
        if (sel && !mem_oe_n && mem_we_n) begin
            mem_dq_in[7:0]  = mem_lb_n ? 8'h5A : peek_sram(int'(mem_addr))[7:0];
            mem_dq_in[15:8] = mem_ub_n ? 8'h5A : peek_sram(int'(mem_addr))[15:8];
        end
    end

    always @(posedge clk) begin
        if (!rst && sel && !mem_we_n) begin
            logic [15:0] w;
            w = peek_sram(int'(mem_addr));
            if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
            sram[int'(mem_addr)] = w;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_parked(input string req);
        chk(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n
            && !mem_dq_oe && !req_ready, req, "parked pins",
            {25'd0, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe},
            32'b1011110);
    endtask

    // Continuous bus-safety monitor (R9).
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(!(mem_dq_oe && sel && !mem_oe_n), "R9", "bus contention", {31'd0, mem_dq_oe}, 32'd0);
            chk(!(sel && mem_ub_n && mem_lb_n), "R9", "select without strobe", {31'd0, sel}, 32'd0);
        end
    end

    task automatic run_req(input bit w, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
        bit turn;
        int total;
        logic [15:0] expd;
        turn  = w && prev_read && (be != 2'b00);
        total = (be == 2'b00) ? 1 : WAITN + (turn ? 1 : 0) + 1;
        expd  = peek_shadow(int'(a)) & {{8{be[1]}}, {8{be[0]}}};
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        for (int c = 1; c <= total; c++) begin
            @(posedge clk); @(negedge clk);
            if (be == 2'b00) begin
                chk(req_ready === 1'b1, "R8", "ready after empty request", {31'd0, req_ready}, 32'd1);
                chk(mem_cs1_n && !mem_cs2, "R8", "memory not selected", {30'd0, mem_cs1_n, mem_cs2}, 32'b10);
                if (!w) chk(rsp_rdata == 16'h0, "R8", "empty read data", {16'd0, rsp_rdata}, 32'd0);
            end else if (turn && c == 1) begin
                chk(mem_cs1_n && !mem_cs2 && !mem_dq_oe && !req_ready, "R7", "turnaround cycle parked",
                    {29'd0, mem_cs1_n, mem_cs2, mem_dq_oe}, 32'b100);
            end else if (c < total) begin
                chk(sel && !req_ready, "R2", "selected in window", {30'd0, sel, req_ready}, 32'b10);
                chk(mem_addr == a, "R3", "address held", {16'd0, mem_addr}, {16'd0, a});
                chk(mem_lb_n == !be[0] && mem_ub_n == !be[1], "R5", "lane strobes",
                    {30'd0, mem_ub_n, mem_lb_n}, {30'd0, !be[1], !be[0]});
                if (w) begin
                    chk(!mem_we_n && mem_oe_n && mem_dq_oe, "R3", "write controls",
                        {29'd0, mem_we_n, mem_oe_n, mem_dq_oe}, 32'b011);
                    chk(mem_dq_out == d, "R3", "write data", {16'd0, mem_dq_out}, {16'd0, d});
                end else begin
                    chk(mem_we_n && !mem_oe_n && !mem_dq_oe, "R4", "read controls",
                        {29'd0, mem_we_n, mem_oe_n, mem_dq_oe}, 32'b100);
                end
            end else begin
                chk(req_ready === 1'b1 && !sel, "R2", "ready after window", {30'd0, req_ready, sel}, 32'b10);
                if (w) begin
                    chk(mem_we_n && mem_dq_oe && mem_addr == a && mem_dq_out == d, "R6",
                        "write release hold", {mem_dq_out, mem_addr}, {d, a});
                end else begin
                    chk(rsp_rdata == expd, (be == 2'b11) ? "R4" : "R5", "read data",
                        {16'd0, rsp_rdata}, {16'd0, expd});
                end
            end
        end
        req_valid = 1'b0;
        if (w && be != 2'b00)
            shadow[int'(a)] = (peek_shadow(int'(a)) & ~{{8{be[1]}}, {8{be[0]}}}) | (d & {{8{be[1]}}, {8{be[0]}}});
        if (be != 2'b00) prev_read = !w;
        @(posedge clk); @(negedge clk);
        chk_parked("R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_parked("R1");
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_parked("R1");

        run_req(1'b1, 16'h1234, 16'hA1B2, 2'b11);
        run_req(1'b0, 16'h1234, 16'h0000, 2'b11);
        run_req(1'b1, 16'h1234, 16'h77CC, 2'b01);   // R7 turnaround, R5 low lane only
        run_req(1'b0, 16'h1234, 16'h0000, 2'b11);
        run_req(1'b0, 16'h1234, 16'h0000, 2'b10);   // R5 upper lane, read after read
        run_req(1'b1, 16'h1234, 16'hFFFF, 2'b00);   // R8 empty write
        chk(peek_sram(32'h1234) == 16'hA1CC, "R8", "memory untouched",
            {16'd0, peek_sram(32'h1234)}, 32'h0000A1CC);
        run_req(1'b1, 16'hFFFF, 16'h0102, 2'b11);   // R7 still turns after empty request
        run_req(1'b1, 16'hFFFF, 16'h9E4F, 2'b10);   // write after write
        run_req(1'b0, 16'hFFFF, 16'h0000, 2'b11);
        run_req(1'b0, 16'hFFFF, 16'h0000, 2'b00);   // R8 empty read
        run_req(1'b0, 16'h1234, 16'h0000, 2'b01);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule